// File: doc/BRIEF.md
# Partitioned NVRAM Address Decoder

This block sits between a processor core and a byte-wide nonvolatile RAM. Each cycle the core presents one access: a program fetch or a data-space access, read or write, with a 16-bit core address. The block decides where that access goes. It can go to the RAM, to a real-time-clock window, or to the expanded external bus. It can also be dropped. The block then drives the matching select lines, a gated write strobe and the physical RAM address.

Three inputs choose the mapping:
- **Flat mode.** The lower half of the RAM holds program space and the upper half holds data space.
- **Partitioned mode.** The RAM is split at a movable boundary with 4 KiB granularity. The boundary code is clamped to the RAM size. Program sits below the boundary and is write-protected. Data sits above it. Data addresses are used unchanged as RAM addresses. Data addresses past the top of the RAM go to the expanded bus.
- **Clock-window mode.** Every data-space access is steered to the clock.

A lockout input silences everything. A RAM wider than 64 KiB always runs flat. All outputs are registered, so there is one cycle from the request to the selects.

Top module: `nvram_part_decoder`

## Requirements
- R1: During and right after synchronous reset, all chip enables are high, `rtc_ce_n` and `we_n` are high, `xbus_sel` is low and `ram_addr` is 0.
- R2: Outputs reflect the access presented at the previous rising clock edge (one-cycle latency).
- R3: Flat mode, with half = RAM size / 2:
  - A fetch below half selects RAM at the same address.
  - A data access below half selects RAM at address half + addr.
  - A permitted write drives `we_n` low.
- R4: Flat mode: a data access at or above half selects the expanded bus, with `we_n` low for writes. A fetch at or above half selects nothing.
- R5: Partitioned mode: boundary = min(`part_code` × 4096, RAM size), where `part_code` is a 5-bit unsigned value.
- R6: Partitioned mode: a fetch below the boundary selects RAM at the same address. A fetch at or above the boundary selects nothing.
- R7: Partitioned mode, data access at or above the boundary:
  - Below the RAM size, it selects RAM at the same address, reads and writes.
  - At or above the RAM size, it selects the expanded bus.
- R8: Partitioned mode: a data write below the boundary selects nothing and keeps `we_n` high. A data read below the boundary selects RAM at the same address.
- R9: With `clk_win` high:
  - Every data access drives `rtc_ce_n` low and selects neither RAM nor the bus.
  - `we_n` is low exactly for writes.
  - Fetches are unaffected.
- R10: With `lockout` high, the next cycle has nothing selected and `we_n` high.
- R11: At most one of RAM, clock and bus is selected. Exactly one RAM chip enable is low when RAM is selected: the one numbered by `ram_addr` bits [RAM_AW-1:BANK_AW]. `ram_addr` is 0 when RAM is not selected.
- R12: When RAM_AW exceeds 16, `flat_mode` low is ignored and the flat mapping applies.
- R13: With `acc_valid` low, nothing is selected. `acc_write` has no effect on fetches, and fetches never drive `we_n` low or select the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_data | input | 1 | 1 = data-space access, 0 = program fetch |
| acc_write | input | 1 | 1 = write (data space only) |
| acc_addr | input | 16 | Core address |
| flat_mode | input | 1 | 1 = flat mapping, 0 = partitioned |
| part_code | input | 5 | Partition boundary in 4 KiB units |
| clk_win | input | 1 | Steer data accesses to the clock window |
| lockout | input | 1 | Suppress every select and the write strobe |
| ram_ce_n | output | 2^(RAM_AW-BANK_AW) | Active-low RAM bank enables |
| rtc_ce_n | output | 1 | Active-low clock enable |
| xbus_sel | output | 1 | Expanded-bus select |
| we_n | output | 1 | Gated active-low write strobe |
| ram_addr | output | RAM_AW | Physical RAM address |

## Verification
The assertions assume that mode inputs and `lockout` are sampled with the access in the same cycle, and that `part_code` may take any value, including codes beyond the RAM size. The protection and window properties treat those inputs as qualifying only the access of that cycle.

The bench drives every input on the falling edge. It holds each access for exactly one cycle, and it applies random addresses, codes and mode bits only through that same path. It runs a 64 KiB and a 128 KiB instance side by side against one behavioural reference.

// File: rtl/nvdec_pkg.sv
// Shared types for the partitioned NVRAM decoder.
// Assumes a 16-bit core address space.
package nvdec_pkg;
    localparam int CORE_AW = 16;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_RTC  = 2'd2,
        TGT_XBUS = 2'd3
    } tgt_e;
endpackage

// File: rtl/nvdec_bound.sv
// Computes the effective partition boundary and whether partitioning is active.
// Assumes CW is wide enough to hold both the RAM size and part_code << PAGE_AW.
module nvdec_bound
    import nvdec_pkg::*;
#(
    parameter int RAM_AW  = 16,
    parameter int PAGE_AW = 12,
    parameter int CW      = 18
) (
    input  logic                     flat_mode,
    input  logic [CORE_AW-PAGE_AW:0] part_code,
    output logic [CW-1:0]            bound,
    output logic                     part_en
);
    localparam logic [CW-1:0] RAM_SIZE = CW'(1) << RAM_AW;

    logic [CW-1:0] raw_bound;

    // Scale the code to bytes and clamp it to the top of RAM.
    always_comb begin
        raw_bound = CW'(part_code) << PAGE_AW;
        bound     = (raw_bound > RAM_SIZE) ? RAM_SIZE : raw_bound;
    end

    // A RAM wider than the core space only supports the flat mapping.
    generate
        if (RAM_AW > CORE_AW) begin : g_flat_only
            assign part_en = 1'b0;
        end else begin : g_part_ok
            assign part_en = ~flat_mode;
        end
    endgenerate
endmodule

// File: rtl/nvdec_classify.sv
// Classifies one access into a target and computes the physical RAM address.
// Assumes bound <= RAM size; purely combinational.
module nvdec_classify
    import nvdec_pkg::*;
#(
    parameter int RAM_AW = 16,
    parameter int CW     = 18
) (
    input  logic               acc_valid,
    input  logic               acc_data,
    input  logic               acc_write,
    input  logic [CORE_AW-1:0] acc_addr,
    input  logic               part_en,
    input  logic [CW-1:0]      bound,
    input  logic               clk_win,
    input  logic               lockout,
    output tgt_e               tgt,
    output logic [RAM_AW-1:0]  phys,
    output logic               wr_ok
);
    localparam logic [CW-1:0] RAM_SIZE = CW'(1) << RAM_AW;
    localparam logic [CW-1:0] HALF     = RAM_SIZE >> 1;

    logic [CW-1:0] a;

    // Decide the target, the write permission and the RAM address.
    always_comb begin
        a     = CW'(acc_addr);
        tgt   = TGT_NONE;
        phys  = '0;
        wr_ok = 1'b0;
        if (acc_valid && !lockout) begin
            if (!acc_data) begin
                if (part_en ? (a < bound) : (a < HALF)) begin
                    tgt  = TGT_RAM;
                    phys = a[RAM_AW-1:0];
                end
            end else if (clk_win) begin
                tgt   = TGT_RTC;
                wr_ok = acc_write;
            end else if (!part_en) begin
                if (a < HALF) begin
                    tgt   = TGT_RAM;
                    phys  = a[RAM_AW-1:0] + HALF[RAM_AW-1:0];
                    wr_ok = acc_write;
                end else begin
                    tgt   = TGT_XBUS;
                    wr_ok = acc_write;
                end
            end else if (a < bound) begin
                if (!acc_write) begin
                    tgt  = TGT_RAM;
                    phys = a[RAM_AW-1:0];
                end
            end else if (a < RAM_SIZE) begin
                tgt   = TGT_RAM;
                phys  = a[RAM_AW-1:0];
                wr_ok = acc_write;
            end else begin
                tgt   = TGT_XBUS;
                wr_ok = acc_write;
            end
        end
    end
endmodule

// File: rtl/nvdec_drive.sv
// Registers the decision and drives the bank enables, clock enable,
// bus select and write strobe.
// Assumes RAM_AW > BANK_AW.
module nvdec_drive
    import nvdec_pkg::*;
#(
    parameter int RAM_AW  = 16,
    parameter int BANK_AW = 15
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  tgt_e                           tgt,
    input  logic [RAM_AW-1:0]              phys,
    input  logic                           wr_ok,
    output logic [(1<<(RAM_AW-BANK_AW))-1:0] ram_ce_n,
    output logic                           rtc_ce_n,
    output logic                           xbus_sel,
    output logic                           we_n,
    output logic [RAM_AW-1:0]              ram_addr
);
    localparam int BSEL_W = RAM_AW - BANK_AW;
    localparam int NBANK  = 1 << BSEL_W;

    logic ram_q, rtc_q, xbus_q;

    // Capture the decision of this cycle; reset to all inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_q    <= 1'b0;
            rtc_q    <= 1'b0;
            xbus_q   <= 1'b0;
            we_n     <= 1'b1;
            ram_addr <= '0;
        end else begin
            ram_q    <= (tgt == TGT_RAM);
            rtc_q    <= (tgt == TGT_RTC);
            xbus_q   <= (tgt == TGT_XBUS);
            we_n     <= !(wr_ok && (tgt != TGT_NONE));
            ram_addr <= (tgt == TGT_RAM) ? phys : '0;
        end
    end

    assign rtc_ce_n = ~rtc_q;
    assign xbus_sel = xbus_q;

    // One active-low enable per bank, decoded from the upper address bits.
    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_bank
            assign ram_ce_n[i] = !(ram_q && (ram_addr[RAM_AW-1:BANK_AW] == BSEL_W'(i)));
        end
    endgenerate

    // R11
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!(&ram_ce_n), !rtc_ce_n, xbus_sel}));
    // R11
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ram_ce_n));
    // R11
    strobe_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!(&ram_ce_n) || !rtc_ce_n || xbus_sel));
endmodule

// File: rtl/nvram_part_decoder.sv
// Top of the partitioned NVRAM decoder: boundary logic, access
// classification and registered output drive.
// Assumes one access per cycle, with mode inputs valid alongside it.
module nvram_part_decoder
    import nvdec_pkg::*;
#(
    parameter int RAM_AW  = 16,
    parameter int BANK_AW = 15,
    parameter int PAGE_AW = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_valid,
    input  logic                             acc_data,
    input  logic                             acc_write,
    input  logic [CORE_AW-1:0]               acc_addr,
    input  logic                             flat_mode,
    input  logic [CORE_AW-PAGE_AW:0]         part_code,
    input  logic                             clk_win,
    input  logic                             lockout,
    output logic [(1<<(RAM_AW-BANK_AW))-1:0] ram_ce_n,
    output logic                             rtc_ce_n,
    output logic                             xbus_sel,
    output logic                             we_n,
    output logic [RAM_AW-1:0]                ram_addr
);
    localparam int CW = ((CORE_AW > RAM_AW) ? CORE_AW : RAM_AW) + 2;

    logic [CW-1:0]     bound;
    logic              part_en;
    tgt_e              tgt;
    logic [RAM_AW-1:0] phys;
    logic              wr_ok;

    nvdec_bound #(.RAM_AW(RAM_AW), .PAGE_AW(PAGE_AW), .CW(CW)) u_bound (
        .flat_mode (flat_mode),
        .part_code (part_code),
        .bound     (bound),
        .part_en   (part_en)
    );

    nvdec_classify #(.RAM_AW(RAM_AW), .CW(CW)) u_class (
        .acc_valid (acc_valid),
        .acc_data  (acc_data),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .part_en   (part_en),
        .bound     (bound),
        .clk_win   (clk_win),
        .lockout   (lockout),
        .tgt       (tgt),
        .phys      (phys),
        .wr_ok     (wr_ok)
    );

    nvdec_drive #(.RAM_AW(RAM_AW), .BANK_AW(BANK_AW)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .phys     (phys),
        .wr_ok    (wr_ok),
        .ram_ce_n (ram_ce_n),
        .rtc_ce_n (rtc_ce_n),
        .xbus_sel (xbus_sel),
        .we_n     (we_n),
        .ram_addr (ram_addr)
    );

    // R10
    lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (&ram_ce_n) && rtc_ce_n && !xbus_sel && we_n);
    // R13
    fetch_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_data) |=> !xbus_sel && rtc_ce_n && we_n);
    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (&ram_ce_n) && rtc_ce_n && !xbus_sel && we_n);
    // R8
    program_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_data && acc_write && part_en && !clk_win && !lockout
         && (CW'(acc_addr) < bound)) |=> we_n && (&ram_ce_n) && !xbus_sel);
    // R9
    clock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_data && clk_win && !lockout) |=> !rtc_ce_n && (&ram_ce_n) && !xbus_sel);
    // R5
    bound_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bound <= (CW'(1) << RAM_AW));
endmodule

// File: tb/tb_nvram_part_decoder.sv
// Bench: a 64 KiB and a 128 KiB decoder share stimulus and are compared
// every clock against a behavioural reference.
module tb_nvram_part_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_data = 1'b0, acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        flat_mode = 1'b1;
    logic [4:0]  part_code = '0;
    logic        clk_win = 1'b0, lockout = 1'b0;

    logic [1:0]  s_ce_n; logic s_rtc_n, s_xb, s_we_n; logic [15:0] s_addr;
    logic [3:0]  b_ce_n; logic b_rtc_n, b_xb, b_we_n; logic [16:0] b_addr;

    int checks = 0, fails = 0, cycles = 0;
    string cur_tag = "R1";
    int e_s_bank, e_s_pa, e_b_bank, e_b_pa;
    bit e_s_rtc, e_s_xb, e_s_we, e_b_rtc, e_b_xb, e_b_we;
    bit cur_flat = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvram_part_decoder dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_data(acc_data),
        .acc_write(acc_write), .acc_addr(acc_addr), .flat_mode(flat_mode),
        .part_code(part_code), .clk_win(clk_win), .lockout(lockout),
        .ram_ce_n(s_ce_n), .rtc_ce_n(s_rtc_n), .xbus_sel(s_xb), .we_n(s_we_n),
        .ram_addr(s_addr));

    nvram_part_decoder #(.RAM_AW(17)) dut_big (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_data(acc_data),
        .acc_write(acc_write), .acc_addr(acc_addr), .flat_mode(flat_mode),
        .part_code(part_code), .clk_win(clk_win), .lockout(lockout),
        .ram_ce_n(b_ce_n), .rtc_ce_n(b_rtc_n), .xbus_sel(b_xb), .we_n(b_we_n),
        .ram_addr(b_addr));

    // Behavioural reference of the mapping rules.
    task automatic model(input int aw, input bit rst, v, d, w, input int addr,
                         input bit flat, input int code, input bit win, lock,
                         output int bank, output bit rtc_n, xb, wen, output int pa);
        int size, half, bnd, tgt;
        bit pe, wok;
        size = 1 << aw; half = size / 2;
        bnd = code * 4096; if (bnd > size) bnd = size;
        pe = !flat && (aw <= 16);
        tgt = 0; wok = 0; pa = 0;
        if (rst && v && !lock) begin
            if (!d) begin
                if (pe ? (addr < bnd) : (addr < half)) begin tgt = 1; pa = addr; end
            end else if (win) begin tgt = 2; wok = w; end
            else if (!pe) begin
                if (addr < half) begin tgt = 1; pa = addr + half; wok = w; end
                else begin tgt = 3; wok = w; end
            end else if (addr < bnd) begin
                if (!w) begin tgt = 1; pa = addr; end
            end else if (addr < size) begin tgt = 1; pa = addr; wok = w; end
            else begin tgt = 3; wok = w; end
        end
        bank  = (tgt == 1) ? (pa >> 15) : -1;
        rtc_n = (tgt != 2);
        xb    = (tgt == 3);
        wen   = !(wok && tgt != 0);
        if (tgt != 1) pa = 0;
    endtask

    task automatic cmp(string who, string tag, int nb, int ce_act, bit rtc_a, xb_a, we_a,
                       int pa_a, int bank, bit rtc_e, xb_e, we_e, int pa_e);
        int ce_e;
        ce_e = (1 << nb) - 1;
        if (bank >= 0) ce_e = ce_e & ~(1 << bank);
        checks++;
        if (ce_act != ce_e || rtc_a != rtc_e || xb_a != xb_e || we_a != we_e || pa_a != pa_e) begin
            fails++;
            $display("FAIL %s %s: ce_n=%0h rtc_n=%0b xbus=%0b we_n=%0b addr=%0h expected ce_n=%0h rtc_n=%0b xbus=%0b we_n=%0b addr=%0h",
                     tag, who, ce_act, rtc_a, xb_a, we_a, pa_a, ce_e, rtc_e, xb_e, we_e, pa_e);
        end
    endtask

    // Check the previous access, then apply the next one.
    task automatic step(string tag, bit r, v, d, w, int addr, bit flat, int code, bit win, lock);
        @(negedge clk);
        cmp("small", cur_tag, 2, int'(s_ce_n), s_rtc_n, s_xb, s_we_n, int'(s_addr),
            e_s_bank, e_s_rtc, e_s_xb, e_s_we, e_s_pa);
        cmp("big", cur_flat ? cur_tag : "R12", 4, int'(b_ce_n), b_rtc_n, b_xb, b_we_n, int'(b_addr),
            e_b_bank, e_b_rtc, e_b_xb, e_b_we, e_b_pa);
        rst_n = r; acc_valid = v; acc_data = d; acc_write = w; acc_addr = addr[15:0];
        flat_mode = flat; part_code = code[4:0]; clk_win = win; lockout = lock;
        model(16, r, v, d, w, addr, flat, code, win, lock, e_s_bank, e_s_rtc, e_s_xb, e_s_we, e_s_pa);
        model(17, r, v, d, w, addr, flat, code, win, lock, e_b_bank, e_b_rtc, e_b_xb, e_b_we, e_b_pa);
        cur_tag = tag; cur_flat = flat;
    endtask

    initial begin
        model(16, 0, 0, 0, 0, 0, 1, 0, 0, 0, e_s_bank, e_s_rtc, e_s_xb, e_s_we, e_s_pa);
        model(17, 0, 0, 0, 0, 0, 1, 0, 0, 0, e_b_bank, e_b_rtc, e_b_xb, e_b_we, e_b_pa);
        @(posedge clk);
        // R1 reset with an access pending
        step("R1", 0, 1, 1, 1, 16'h0010, 1, 0, 0, 0);
        step("R1", 0, 1, 0, 0, 16'h0000, 1, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 16'h0000, 1, 0, 0, 0);
        // R13 idle and fetch with write flag
        step("R13", 1, 0, 1, 1, 16'h1234, 1, 0, 0, 0);
        step("R13", 1, 1, 0, 1, 16'h0100, 1, 0, 0, 0);
        // R3 flat lower half
        step("R3", 1, 1, 0, 0, 16'h0000, 1, 0, 0, 0);
        step("R3", 1, 1, 0, 0, 16'h7FFF, 1, 0, 0, 0);
        step("R3", 1, 1, 1, 0, 16'h0010, 1, 0, 0, 0);
        step("R3", 1, 1, 1, 1, 16'h7FFF, 1, 0, 0, 0);
        // R4 flat upper half
        step("R4", 1, 1, 0, 0, 16'h8000, 1, 0, 0, 0);
        step("R4", 1, 1, 0, 0, 16'hFFFF, 1, 0, 0, 0);
        step("R4", 1, 1, 1, 1, 16'h8000, 1, 0, 0, 0);
        step("R4", 1, 1, 1, 0, 16'hFFFF, 1, 0, 0, 0);
        // R5/R6 partition boundaries
        step("R6", 1, 1, 0, 0, 16'h7FFF, 0, 8, 0, 0);
        step("R6", 1, 1, 0, 0, 16'h8000, 0, 8, 0, 0);
        step("R5", 1, 1, 0, 0, 16'h0000, 0, 0, 0, 0);
        step("R11", 1, 1, 0, 0, 16'hFFFF, 0, 16, 0, 0);
        step("R5", 1, 1, 0, 0, 16'hFFFF, 0, 31, 0, 0);
        step("R5", 1, 1, 1, 1, 16'hFFFF, 0, 31, 0, 0);
        // R7 data region above the boundary
        step("R7", 1, 1, 1, 0, 16'h4000, 0, 4, 0, 0);
        step("R7", 1, 1, 1, 1, 16'hC123, 0, 4, 0, 0);
        step("R7", 1, 1, 1, 1, 16'h0000, 0, 0, 0, 0);
        // R8 write protection of program region
        step("R8", 1, 1, 1, 1, 16'h3FFF, 0, 4, 0, 0);
        step("R8", 1, 1, 1, 0, 16'h3FFF, 0, 4, 0, 0);
        step("R8", 1, 1, 1, 1, 16'hFFFF, 0, 16, 0, 0);
        // R9 clock window
        step("R9", 1, 1, 1, 1, 16'h1234, 0, 4, 1, 0);
        step("R9", 1, 1, 1, 0, 16'hF000, 1, 0, 1, 0);
        step("R9", 1, 1, 0, 0, 16'h0100, 1, 0, 1, 0);
        // R10 lockout
        step("R10", 1, 1, 0, 0, 16'h0100, 1, 0, 0, 1);
        step("R10", 1, 1, 1, 1, 16'h9000, 1, 0, 1, 1);
        step("R10", 1, 1, 1, 1, 16'h8000, 0, 2, 0, 1);
        // R2 back-to-back random accesses
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step("R2", 1, rv[0] | rv[1], rv[2], rv[3], int'(rv[31:16]), rv[4], int'(rv[9:5]),
                 rv[10] & rv[11], rv[12] & rv[13] & rv[14]);
        end
        step("R1", 0, 1, 1, 1, 16'h0000, 1, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 16'h0000, 1, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL R2 watchdog expired: cycles=%0d expected below 5000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule